// File: doc/BRIEF.md
# Configuration Bus Slave with Chip-Select Gating

This block is a two-wire serial management slave that exposes a small configuration and status map of nine byte-wide registers. A free-running system clock oversamples the bus clock and data lines; the slave detects start, repeated start and stop conditions on its own. A host writes one register per transfer and reads one register per transfer. Each transfer first sends a register index, and a read then switches direction with a repeated start.

A chip-select input must be high for the slave to take any part in bus traffic. This lets several identical slaves share one fixed bus address. The three lowest indices show live status bytes taken from input pins. The six registers above them are writable, come out of reset with fixed nonzero defaults where the map calls for them, and are presented in parallel on an output bus. The slave pulls the data line low only, through an output-enable, and never drives it high.

Top module: `cfgbus_slave`

## Requirements
- R1: The slave acknowledges only an address byte whose upper seven bits equal 1010110 (0xAC for a write, 0xAD for a read). Any other address gets no acknowledge, and the rest of that transfer is neither acknowledged nor acted on.
- R2: While chipSel is low, sdaOe stays low and bus traffic changes no register.
- R3: A write (start, 0xAC, index, data, stop) is acknowledged on all three bytes and loads the data into the writable register at that index.
- R4: A read (start, 0xAC, index, repeated start, 0xAD, then eight clocks driven by the slave, MSB first) returns the register at that index. Indices 0, 1 and 2 return statusIn[7:0], statusIn[15:8] and statusIn[23:16], sampled at the time of the read.
- R5: After reset, register 3 and register 4 hold 0x44, registers 5 to 7 hold 0x00 and register 8 holds 0x78. Register k (3 to 8) appears on regOut[8*(k-3)+7 : 8*(k-3)].
- R6: Writes to indices 0 to 2 or to any index of 9 or above are acknowledged on every byte but change nothing. Reads of indices of 9 or above return 0x00.
- R7: If the bus clock stays low for TIMEOUT_CYC system clocks during a transfer, the slave releases the data line and returns to idle, and it accepts the next transfer normally.
- R8: The slave changes sdaOe only while the bus clock is low, so it never creates a start or stop condition.
- R9: A stop received after the index byte, before any data byte, ends the transfer with no register changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| chipSel | input | 1 | High to allow the slave on the bus |
| sclIn | input | 1 | Bus clock level |
| sdaIn | input | 1 | Bus data level, as seen on the wire |
| statusIn | input | 8*NUM_RO | Read-only status bytes, index 0 in the low byte |
| sdaOe | output | 1 | High to pull the data line low |
| regOut | output | 8*NUM_RW | Writable registers 3 to 8, register 3 in the low byte |

## Verification
The bench goes after the edges of the map. It reads every index from 0 to 9 and 0xFF: a slave that decoded the map off by one would return a default from the wrong place, and one that failed to clear the read value would return stale data above index 8. It writes to the read-only and unused indices, where a design that wrote through would corrupt a neighbouring writable register. It sends a wrong address, a transfer with chip select low, and a transfer that stops after the index; these catch a slave that acknowledges a foreign address, that drives the line while deselected, or that commits a write half-done. Finally it holds the bus clock low in the middle of an acknowledge, which a slave with no timeout would answer by pulling the data line low for ever.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_INDEX,
    ST_ACK_INDEX,
    ST_WDATA,
    ST_ACK_DATA,
    ST_RDATA,
    ST_RACK,
    ST_WAIT
  } busState_t;

  // strobes from the control FSM to the register datapath
  typedef struct packed {
    logic shiftIn;   // take one received bit
    logic latchIdx;  // received byte becomes the register index
    logic commitWr;  // received byte is written to the indexed register
    logic loadTx;    // load the read value for sending
    logic shiftTx;   // advance to the next outgoing bit
  } dpStrobe_t;

  // reset value of a writable register, by absolute index
  function automatic logic [7:0] rwDefault(input int idx);
    case (idx)
      3, 4:    return 8'h44;
      8:       return 8'h78;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfgbus_ctrl.sv
module cfgbus_ctrl
  import cfgbus_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h56,
  parameter int         TIMEOUT_CYC = 5_000_000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      chipSel,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic [7:0] rxByte,
  input  logic      txBit,
  output logic      sdaSample,
  output dpStrobe_t strobe,
  output logic      sdaOe
);

  localparam int TO_W = $clog2(TIMEOUT_CYC + 1);

  logic [2:0] sclPipe, sdaPipe;
  busState_t  state, nxtState;
  logic [3:0] bitCnt, nxtBitCnt;
  logic       readMode, nxtReadMode;
  logic [TO_W-1:0] toCnt;

  logic sclRise, sclFall, startDet, stopDet, toHit;

  // two flops against metastability, a third for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= 3'b111;
      sdaPipe <= 3'b111;
    end else begin
      sclPipe <= {sclPipe[1:0], sclIn};
      sdaPipe <= {sdaPipe[1:0], sdaIn};
    end
  end

  assign sdaSample = sdaPipe[1];
  assign sclRise   = sclPipe[1] & ~sclPipe[2];
  assign sclFall   = ~sclPipe[1] & sclPipe[2];
  assign startDet  = sclPipe[1] & sclPipe[2] & sdaPipe[2] & ~sdaPipe[1];
  assign stopDet   = sclPipe[1] & sclPipe[2] & ~sdaPipe[2] & sdaPipe[1];
  assign toHit     = (toCnt == TO_W'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toCnt <= '0;
    end else if (state == ST_IDLE || sclPipe[1]) begin
      toCnt <= '0;
    end else if (!toHit) begin
      toCnt <= toCnt + 1'b1;
    end
  end

  always_comb begin
    nxtState    = state;
    nxtBitCnt   = bitCnt;
    nxtReadMode = readMode;
    strobe      = '0;
    if (!chipSel) begin
      nxtState = ST_IDLE;
    end else if (startDet) begin
      nxtState  = ST_ADDR;
      nxtBitCnt = '0;
    end else if (stopDet || (state != ST_IDLE && toHit)) begin
      nxtState = ST_IDLE;
    end else begin
      case (state)
        ST_ADDR, ST_INDEX, ST_WDATA: begin
          if (sclRise && bitCnt != 4'd8) begin
            strobe.shiftIn = 1'b1;
            nxtBitCnt      = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            if (state == ST_ADDR) begin
              if (rxByte[7:1] == DEV_ADDR) begin
                nxtState    = ST_ACK_ADDR;
                nxtReadMode = rxByte[0];
              end else begin
                nxtState = ST_WAIT;
              end
            end else if (state == ST_INDEX) begin
              strobe.latchIdx = 1'b1;
              nxtState        = ST_ACK_INDEX;
            end else begin
              strobe.commitWr = 1'b1;
              nxtState        = ST_ACK_DATA;
            end
          end
        end
        ST_ACK_ADDR: if (sclFall) begin
          nxtBitCnt = '0;
          if (readMode) begin
            strobe.loadTx = 1'b1;
            nxtState      = ST_RDATA;
          end else begin
            nxtState = ST_INDEX;
          end
        end
        ST_ACK_INDEX: if (sclFall) begin
          nxtBitCnt = '0;
          nxtState  = ST_WDATA;
        end
        ST_ACK_DATA: if (sclFall) nxtState = ST_WAIT;
        ST_RDATA: if (sclFall) begin
          if (bitCnt == 4'd7) begin
            nxtState = ST_RACK;
          end else begin
            strobe.shiftTx = 1'b1;
            nxtBitCnt      = bitCnt + 4'd1;
          end
        end
        ST_RACK: if (sclFall) nxtState = ST_WAIT;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      readMode <= 1'b0;
    end else begin
      state    <= nxtState;
      bitCnt   <= nxtBitCnt;
      readMode <= nxtReadMode;
    end
  end

  assign sdaOe = chipSel & ((state == ST_ACK_ADDR) | (state == ST_ACK_INDEX) |
                            (state == ST_ACK_DATA) | ((state == ST_RDATA) & ~txBit));

endmodule

// File: rtl/cfgbus_regs.sv
module cfgbus_regs
  import cfgbus_pkg::*;
#(
  parameter int NUM_RO = 3,
  parameter int NUM_RW = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic                sdaSample,
  input  logic [8*NUM_RO-1:0] statusIn,
  output logic [7:0]          rxByte,
  output logic                txBit,
  output logic [8*NUM_RW-1:0] regOut
);

  logic [7:0] regIdx, txShift, readByte;
  logic [7:0] rwReg [NUM_RW];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      regIdx  <= '0;
      txShift <= '0;
    end else begin
      if (strobe.shiftIn)  rxByte <= {rxByte[6:0], sdaSample};
      if (strobe.latchIdx) regIdx <= rxByte;
      if (strobe.loadTx)       txShift <= readByte;
      else if (strobe.shiftTx) txShift <= {txShift[6:0], 1'b0};
    end
  end

  assign txBit = txShift[7];

  genvar g;
  generate
    for (g = 0; g < NUM_RW; g++) begin : gRw
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          rwReg[g] <= rwDefault(NUM_RO + g);
        end else if (strobe.commitWr && regIdx == 8'(NUM_RO + g)) begin
          rwReg[g] <= rxByte;
        end
      end
      assign regOut[8*g +: 8] = rwReg[g];
    end
  endgenerate

  always_comb begin
    readByte = 8'h00;
    for (int i = 0; i < NUM_RO; i++) begin
      if (regIdx == 8'(i)) readByte = statusIn[8*i +: 8];
    end
    for (int i = 0; i < NUM_RW; i++) begin
      if (regIdx == 8'(NUM_RO + i)) readByte = rwReg[i];
    end
  end

endmodule

// File: rtl/cfgbus_slave.sv
module cfgbus_slave
  import cfgbus_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h56,
  parameter int         NUM_RO      = 3,
  parameter int         NUM_RW      = 6,
  parameter int         TIMEOUT_CYC = 5_000_000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                chipSel,
  input  logic                sclIn,
  input  logic                sdaIn,
  input  logic [8*NUM_RO-1:0] statusIn,
  output logic                sdaOe,
  output logic [8*NUM_RW-1:0] regOut
);

  dpStrobe_t  strobe;
  logic [7:0] rxByte;
  logic       txBit, sdaSample;

  cfgbus_ctrl #(.DEV_ADDR(DEV_ADDR), .TIMEOUT_CYC(TIMEOUT_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .sclIn(sclIn), .sdaIn(sdaIn),
    .rxByte(rxByte), .txBit(txBit), .sdaSample(sdaSample),
    .strobe(strobe), .sdaOe(sdaOe)
  );

  cfgbus_regs #(.NUM_RO(NUM_RO), .NUM_RW(NUM_RW)) uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaSample(sdaSample),
    .statusIn(statusIn), .rxByte(rxByte), .txBit(txBit), .regOut(regOut)
  );

endmodule

// File: rtl/cfgbus_checker.sv
module cfgbus_checker
  import cfgbus_pkg::*;
#(
  parameter int NUM_RO      = 3,
  parameter int NUM_RW      = 6,
  parameter int TIMEOUT_CYC = 5_000_000
) (
  input logic                clk,
  input logic                rstN,
  input logic                chipSel,
  input logic                sclIn,
  input logic                sdaOe,
  input logic [8*NUM_RW-1:0] regOut
);

  function automatic logic [8*NUM_RW-1:0] allDefaults();
    logic [8*NUM_RW-1:0] v;
    for (int i = 0; i < NUM_RW; i++) v[8*i +: 8] = rwDefault(NUM_RO + i);
    return v;
  endfunction

  localparam logic [8*NUM_RW-1:0] DEFAULTS = allDefaults();

  int unsigned lowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            lowRun <= 0;
    else if (sclIn)                       lowRun <= 0;
    else if (lowRun < TIMEOUT_CYC + 100)  lowRun <= lowRun + 1;
  end

  a_r2_deselected_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !chipSel |-> !sdaOe);

  a_r2_deselected_regs_hold: assert property (@(posedge clk) disable iff (!rstN)
    $past(!chipSel) |-> $stable(regOut));

  a_r5_reset_defaults: assert property (@(posedge clk)
    !rstN |=> (regOut == DEFAULTS));

  a_r7_timeout_release: assert property (@(posedge clk) disable iff (!rstN)
    (lowRun > TIMEOUT_CYC + 8) |-> !sdaOe);

  a_r8_drive_with_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    (chipSel && $past(chipSel) && !$stable(sdaOe)) |-> !sclIn);

endmodule

bind cfgbus_slave cfgbus_checker #(
  .NUM_RO(NUM_RO), .NUM_RW(NUM_RW), .TIMEOUT_CYC(TIMEOUT_CYC)
) uChk (
  .clk(clk), .rstN(rstN), .chipSel(chipSel), .sclIn(sclIn),
  .sdaOe(sdaOe), .regOut(regOut)
);

// File: tb/tb_cfgbus_slave.sv
module tb_cfgbus_slave;

  localparam int TO = 300;
  localparam int Q  = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chipSel = 1'b1;
  logic        sclM = 1'b1;
  logic        sdaM = 1'b1;
  logic [23:0] statusIn = 24'h5AC381;
  logic        sdaOe;
  logic [47:0] regOut;
  logic        sdaBus;

  int nChecks = 0;
  int nFails  = 0;
  bit cmpEn   = 1'b0;
  bit done    = 1'b0;
  int modelReg [9];

  assign sdaBus = sdaM & ~sdaOe;

  always #2.5 clk = ~clk;

  cfgbus_slave #(.TIMEOUT_CYC(TO)) dut (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .sclIn(sclM), .sdaIn(sdaBus),
    .statusIn(statusIn), .sdaOe(sdaOe), .regOut(regOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // reference model compared every clock while the bus is quiet
  logic prevOe = 1'b0, prevScl = 1'b1, prevCs = 1'b1;
  always @(negedge clk) begin
    if (rstN) begin
      if (cmpEn) begin
        for (int k = 3; k < 9; k++) chk("R5/R3 register model", int'(regOut[8*(k-3) +: 8]), modelReg[k]);
      end
      if (!chipSel) chk("R2 sdaOe while deselected", int'(sdaOe), 0);
      if (chipSel && prevCs && sclM && prevScl && sdaOe != prevOe)
        chk("R8 sdaOe changed with scl high", 1, 0);
    end
    prevOe  = sdaOe;
    prevScl = sclM;
    prevCs  = chipSel;
  end

  task automatic startC;
    sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(Q); sdaM = 1'b0; tick(Q); sclM = 1'b0; tick(Q);
  endtask

  task automatic stopC;
    sdaM = 1'b0; tick(Q); sclM = 1'b1; tick(Q); sdaM = 1'b1; tick(2*Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; tick(Q); sclM = 1'b1; tick(2*Q); sclM = 1'b0; tick(Q);
    end
    sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(Q); ack = ~sdaBus; tick(Q); sclM = 1'b0; tick(Q);
  endtask

  task automatic recvByte(output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); sclM = 1'b1; tick(Q); b[i] = sdaBus; tick(Q); sclM = 1'b0;
    end
    tick(Q); sclM = 1'b1; tick(2*Q); sclM = 1'b0; tick(Q);
  endtask

  function automatic int expRead(input int idx);
    if (idx < 3) return int'(statusIn[8*idx +: 8]);
    if (idx < 9) return modelReg[idx];
    return 0;
  endfunction

  task automatic wrReg(input logic [7:0] addrByte, input logic [7:0] idx,
                       input logic [7:0] data, output logic [2:0] acks);
    cmpEn = 1'b0;
    startC;
    sendByte(addrByte, acks[2]);
    sendByte(idx, acks[1]);
    sendByte(data, acks[0]);
    stopC;
    if (chipSel && addrByte == 8'hAC && idx >= 3 && idx < 9) modelReg[idx] = int'(data);
    tick(4);
    cmpEn = 1'b1;
  endtask

  task automatic rdReg(input logic [7:0] idx, output logic [7:0] val, output logic [2:0] acks);
    cmpEn = 1'b0;
    startC;
    sendByte(8'hAC, acks[2]);
    sendByte(idx, acks[1]);
    startC;
    sendByte(8'hAD, acks[0]);
    recvByte(val);
    stopC;
    tick(4);
    cmpEn = 1'b1;
  endtask

  task automatic finishRun;
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finishRun;
    end
  end

  initial begin
    logic [2:0] acks;
    logic [7:0] v;
    logic       a;
    for (int k = 0; k < 9; k++) modelReg[k] = 0;
    modelReg[3] = 'h44; modelReg[4] = 'h44; modelReg[8] = 'h78;
    tick(5);
    chk("R5 reset regOut", int'(regOut == 48'h7800_0000_4444), 1);
    chk("R8 no drive in reset", int'(sdaOe), 0);
    rstN = 1'b1;
    tick(4);
    cmpEn = 1'b1;

    // R4/R5/R6: read every index, defaults and status
    for (int k = 0; k < 10; k++) begin
      rdReg(8'(k), v, acks);
      chk("R4 read acks", int'(acks), 7);
      chk(k < 3 ? "R4 status read" : (k < 9 ? "R5 default read" : "R6 unused read"), int'(v), expRead(k));
    end
    rdReg(8'hFF, v, acks);
    chk("R6 read index 0xFF", int'(v), 0);

    // R3 writes and read back
    wrReg(8'hAC, 8'h03, 8'hA5, acks);
    chk("R3 write acks", int'(acks), 7);
    wrReg(8'hAC, 8'h08, 8'h3C, acks);
    wrReg(8'hAC, 8'h07, 8'hFF, acks);
    for (int k = 3; k < 9; k++) begin
      rdReg(8'(k), v, acks);
      chk("R3 read back", int'(v), expRead(k));
    end

    // R6 writes to read-only and unused indices
    wrReg(8'hAC, 8'h01, 8'hFF, acks);
    chk("R6 read-only write acks", int'(acks), 7);
    wrReg(8'hAC, 8'h20, 8'h11, acks);
    chk("R6 unused write acks", int'(acks), 7);
    rdReg(8'h01, v, acks);
    chk("R6 read-only unchanged", int'(v), 'hC3);

    // R1 wrong address
    wrReg(8'hAE, 8'h04, 8'h99, acks);
    chk("R1 foreign address acks", int'(acks), 0);
    wrReg(8'h2C, 8'h05, 8'h99, acks);
    chk("R1 foreign address acks", int'(acks), 0);

    // R2 chip select low
    chipSel = 1'b0;
    tick(4);
    wrReg(8'hAC, 8'h04, 8'h99, acks);
    chk("R2 deselected acks", int'(acks), 0);
    chipSel = 1'b1;
    tick(4);
    rdReg(8'h04, v, acks);
    chk("R2 register after deselected write", int'(v), 'h44);

    // R9 stop after index
    cmpEn = 1'b0;
    startC;
    sendByte(8'hAC, a);
    sendByte(8'h05, a);
    stopC;
    tick(4);
    cmpEn = 1'b1;
    rdReg(8'h05, v, acks);
    chk("R9 stop after index", int'(v), 0);

    // R4 status follows inputs
    statusIn = 24'h0F1E2D;
    rdReg(8'h02, v, acks);
    chk("R4 changed status", int'(v), 'h0F);

    // R7 clock held low during acknowledge
    cmpEn = 1'b0;
    startC;
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'(8'hAC >> i); tick(Q); sclM = 1'b1; tick(2*Q); sclM = 1'b0; tick(Q);
    end
    sdaM = 1'b1;
    chk("R7 ack driven before timeout", int'(sdaOe), 1);
    tick(TO + 20);
    chk("R7 released after timeout", int'(sdaOe), 0);
    sdaM = 1'b0; tick(Q); sclM = 1'b1; tick(Q); sdaM = 1'b1; tick(2*Q);
    wrReg(8'hAC, 8'h06, 8'h5E, acks);
    chk("R7 recovery write acks", int'(acks), 7);
    rdReg(8'h06, v, acks);
    chk("R7 recovery read", int'(v), 'h5E);

    tick(10);
    done = 1'b1;
    finishRun;
  end

endmodule